// File: doc/BRIEF.md
# Page-Write EEPROM Controller Model

This block is a clock-synchronous model of the control logic in a byte-wide parallel EEPROM. A host drives active-low chip select (`ce_n`), read strobe (`oe_n`) and write strobe (`we_n`), a 17-bit address and an 8-bit data byte. The block samples all of these on the clock. Write cycles load bytes into a page buffer. A load window restarts at the start of every write. When the window runs out, the buffered page enters a self-timed programming phase. At the end of that phase, only the loaded bytes are committed to a small register array.

While programming runs, every read returns a status byte instead of array data. Bit 7 is the complement of bit 7 of the last accepted byte. Bit 6 flips on each new read. Bits 5..0 repeat the same bits of the last accepted byte. Software polls until bit 7 matches its data or bit 6 stops changing. Both time spans are parameters counted in clock cycles.

The controller has four states:
- `ST_IDLE`: no page is open.
- `ST_LOAD`: a page is being filled.
- `ST_PROG`: self-timed programming is running.
- `ST_COMMIT`: a one-cycle array update.

The transitions are:
- first accepted load: `ST_IDLE` to `ST_LOAD`.
- window expiry: `ST_LOAD` to `ST_PROG`.
- programming time elapsed: `ST_PROG` to `ST_COMMIT`.
- always, after one cycle: `ST_COMMIT` to `ST_IDLE`.

Top module: `pgeep_ctrl`

## Requirements
- R1: `dout_en` is 1 in the cycle after a clock edge where `ce_n` and `oe_n` were both sampled low, and 0 otherwise. A write cycle never drives the bus.
- R2: A write cycle is any stretch of cycles with `ce_n`=0, `we_n`=0 and `oe_n`=1. The byte address is taken from the first cycle of the stretch. The data is taken from its last cycle.
- R3: Within an open page, a load is ignored if its `addr[16:8]` differs from `addr[16:8]` of the page's first load.
- R4: Programming starts once LOAD_WIN cycles pass after the most recent write start with no write in progress. A write that starts inside the window keeps the page open.
- R5: Programming lasts PROG_CYC cycles. It is followed by one commit cycle and then a return to idle. An open page always proceeds to programming.
- R6: Every write attempt during programming or commit is ignored.
- R7: During programming, a read at any address returns bit 7 as the complement of bit 7 of the last accepted byte.
- R8: During programming, bit 6 of read data changes on every new read. Bits 5..0 equal those of the last accepted byte.
- R9: After programming ends, a read returns the stored array byte at `addr[ARR_AW-1:0]`.
- R10: Only loaded bytes are committed. Unloaded locations of the page keep their contents. A repeated load to the same location keeps the later byte.
- R11: After reset `dout_en` is 0 and every array byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 17 | Byte address; bits 16..8 select the page |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | Data bus drive enable (0 = high impedance) |

## Verification
The bench loads a page that contains a foreign-page byte, a repeated offset and the page's last offset. It then reads every location back. A design that compared the wrong address bits would store the foreign byte. A design that committed the whole buffer would wipe the unloaded neighbours.

During programming, two successive polls must show complemented bit 7 and differing bit 6. A write attempted in that phase must leave no trace.

A second page is kept open by a load that arrives inside the window. A read after the first window has run out must still see array data and no status. A model that counted from the first load would already be busy.

That same load changes address and data partway through the strobe. The stored byte must be the late data at the early address.

// File: rtl/pgeep_pkg.sv
package pgeep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_PROG   = 2'd2,
        ST_COMMIT = 2'd3
    } pg_state_e;
endpackage

// File: rtl/pgeep_busif.sv
// Samples the strobes and turns them into write-start, byte-load and read-start pulses.
module pgeep_busif #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_act,
    output logic              wr_start,
    output logic              ld_pls,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data,
    output logic              rd_act,
    output logic              rd_start
);
    logic wr_q, rd_q;

    assign wr_act   = !ce_n && !we_n && oe_n;
    assign wr_start = wr_act && !wr_q;
    assign ld_pls   = !wr_act && wr_q;
    assign rd_act   = !ce_n && !oe_n;
    assign rd_start = rd_act && !rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            ld_addr <= '0;
            ld_data <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            // address: later falling strobe = first active cycle
            if (wr_start) ld_addr <= addr;
            // data: earlier rising strobe = last active cycle
            if (wr_act) ld_data <= din;
        end
    end
endmodule

// File: rtl/pgeep_pagebuf.sv
// Page buffer with one valid flag per byte offset.
module pgeep_pagebuf #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8,
    localparam int NB    = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_en,
    input  logic [PAGE_W-1:0] ld_off,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] buf_data [NB],
    output logic [NB-1:0]     buf_vld
);
    for (genvar i = 0; i < NB; i++) begin : g_ent
        logic [DATA_W-1:0] d_q;
        logic              v_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (ld_en && ld_off == PAGE_W'(i)) begin
                d_q <= ld_data;
                v_q <= 1'b1;
            end
        end
        assign buf_data[i] = d_q;
        assign buf_vld[i]  = v_q;
    end
endmodule

// File: rtl/pgeep_array.sv
// Storage array; commits the valid bytes of one page in a single cycle.
module pgeep_array #(
    parameter int DATA_W  = 8,
    parameter int PAGE_W  = 8,
    parameter int ARR_AW  = 9,
    localparam int NB     = 1 << PAGE_W,
    localparam int DEPTH  = 1 << ARR_AW,
    localparam int PGB    = ARR_AW - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [PGB-1:0]    commit_pg,
    input  logic [DATA_W-1:0] buf_data [NB],
    input  logic [NB-1:0]     buf_vld,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_loc
        localparam logic [ARR_AW-1:0] LOC = ARR_AW'(i);
        logic [DATA_W-1:0] c_q;
        logic              we;
        assign we = commit && (LOC[ARR_AW-1:PAGE_W] == commit_pg)
                    && buf_vld[LOC[PAGE_W-1:0]];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  c_q <= '0;
            else if (we) c_q <= buf_data[LOC[PAGE_W-1:0]];
        end
        assign cells[i] = c_q;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/pgeep_ctrl.sv
module pgeep_ctrl #(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 8,
    parameter int ARR_AW   = 9,
    parameter int LOAD_WIN = 16,
    parameter int PROG_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    import pgeep_pkg::*;

    localparam int NB      = 1 << PAGE_W;
    localparam int PG_BITS = ADDR_W - PAGE_W;
    localparam int PGB     = ARR_AW - PAGE_W;
    localparam int WCNT_W  = $clog2(LOAD_WIN + 1);
    localparam int PCNT_W  = $clog2(PROG_CYC + 1);

    logic              wr_act, wr_start, ld_pls, rd_act, rd_start;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] ld_data;

    pg_state_e          st_q, st_d;
    logic [PG_BITS-1:0] page_q;
    logic [DATA_W-1:0]  last_q;
    logic [WCNT_W-1:0]  wcnt_q;
    logic [PCNT_W-1:0]  pcnt_q;
    logic               tog_q, tog_n;
    logic [DATA_W-1:0]  dout_q;
    logic               den_q;

    logic              ld_ok, busy, win_done, prog_done, commit;
    logic [DATA_W-1:0] buf_data [NB];
    logic [NB-1:0]     buf_vld;
    logic [DATA_W-1:0] arr_rd, status;

    pgeep_busif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_act(wr_act), .wr_start(wr_start),
        .ld_pls(ld_pls), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_act(rd_act), .rd_start(rd_start)
    );

    assign busy      = (st_q == ST_PROG) || (st_q == ST_COMMIT);
    assign commit    = (st_q == ST_COMMIT);
    assign ld_ok     = ld_pls && ((st_q == ST_IDLE) ||
                       (st_q == ST_LOAD && ld_addr[ADDR_W-1:PAGE_W] == page_q));
    assign win_done  = (wcnt_q == WCNT_W'(LOAD_WIN)) && !wr_act && !ld_pls;
    assign prog_done = (pcnt_q == PCNT_W'(PROG_CYC - 1));

    pgeep_pagebuf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(commit), .ld_en(ld_ok),
        .ld_off(ld_addr[PAGE_W-1:0]), .ld_data(ld_data),
        .buf_data(buf_data), .buf_vld(buf_vld)
    );

    pgeep_array #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .ARR_AW(ARR_AW)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .commit_pg(page_q[PGB-1:0]), .buf_data(buf_data), .buf_vld(buf_vld),
        .rd_addr(addr[ARR_AW-1:0]), .rd_data(arr_rd)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (ld_ok)     st_d = ST_LOAD;
            ST_LOAD:   if (win_done)  st_d = ST_PROG;
            ST_PROG:   if (prog_done) st_d = ST_COMMIT;
            ST_COMMIT:                st_d = ST_IDLE;
            default:                  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign tog_n  = tog_q ^ (rd_start && busy);
    assign status = {~last_q[DATA_W-1], tog_n, last_q[DATA_W-3:0]};

    // counters, page tracking and read outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            pcnt_q <= '0;
            page_q <= '0;
            last_q <= '0;
            tog_q  <= 1'b0;
            dout_q <= '0;
            den_q  <= 1'b0;
        end else begin
            if (wr_start)                        wcnt_q <= '0;
            else if (wcnt_q != WCNT_W'(LOAD_WIN)) wcnt_q <= wcnt_q + 1'b1;
            if (st_q == ST_PROG) pcnt_q <= pcnt_q + 1'b1;
            else                 pcnt_q <= '0;
            if (ld_ok && st_q == ST_IDLE) page_q <= ld_addr[ADDR_W-1:PAGE_W];
            if (ld_ok) last_q <= ld_data;
            tog_q <= tog_n;
            den_q <= rd_act;
            if (rd_act) dout_q <= busy ? status : arr_rd;
            else        dout_q <= '0;
        end
    end

    assign dout    = dout_q;
    assign dout_en = den_q;
endmodule

// File: rtl/pgeep_chk.sv
module pgeep_chk
    import pgeep_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      ce_n,
    input logic      oe_n,
    input logic      dout_en,
    input pg_state_e st
);
    // R1
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!ce_n && !oe_n));
    // R1
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> !dout_en);
    // R5
    load_to_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |=> (st == ST_LOAD || st == ST_PROG));
    // R6
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> (st == ST_PROG || st == ST_COMMIT));
    // R5
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COMMIT) |=> (st == ST_IDLE));
endmodule

bind pgeep_ctrl pgeep_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .dout_en(dout_en), .st(st_q)
);

// File: tb/pgeep_ctrl_tb_top.sv
module pgeep_ctrl_tb_top;
    localparam int LOAD_WIN = 16;
    localparam int PROG_CYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pgeep_ctrl #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // {address, data written, expected readback after programming}
    localparam logic [32:0] VEC [7] = '{
        {17'h00310, 8'hA5, 8'hA5},
        {17'h00311, 8'h3C, 8'h3C},
        {17'h00411, 8'h77, 8'h00},   // foreign page, ignored (R3)
        {17'h00300, 8'h12, 8'h5E},   // overwritten below (R10)
        {17'h003FF, 8'h80, 8'h80},
        {17'h00300, 8'h5E, 8'h5E},
        {17'h00312, 8'h01, 8'h01}
    };

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp, input logic [7:0] mask);
        n_chk++;
        if ((act & mask) !== (exp & mask)) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h mask=%h", req, act, exp, mask);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d,
                      input logic [16:0] a2, input logic [7:0] d2);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        addr = a2; din = d2;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [16:0] a, output logic [7:0] d,
                      output logic en, output logic en_after);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        en_after = dout_en;
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d, d2;
        logic en, ea;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 dout_en after reset", {7'd0, dout_en}, 8'h00, 8'hFF);
        rd(17'h00100, d, en, ea);
        check("R11 array zero", d, 8'h00, 8'hFF);
        check("R1 read drives bus", {7'd0, en}, 8'h01, 8'hFF);
        check("R1 bus released", {7'd0, ea}, 8'h00, 8'hFF);

        // table: load one page (R2, R3, R10)
        for (int i = 0; i < 7; i++)
            wr(VEC[i][32:16], VEC[i][15:8], VEC[i][32:16], VEC[i][15:8]);
        check("R1 write leaves bus idle", {7'd0, dout_en}, 8'h00, 8'hFF);
        repeat (LOAD_WIN + 4) @(negedge clk);

        // programming: status polls (R7, R8)
        rd(17'h00000, d, en, ea);
        rd(17'h00310, d2, en, ea);
        check("R7 bit7 complement", d, 8'h80, 8'h80);
        check("R8 low bits of last byte", d, 8'h01, 8'h3F);
        check("R7 bit7 second poll", d2, 8'h80, 8'h80);
        check("R8 bit6 toggles", {7'd0, d[6] ^ d2[6]}, 8'h01, 8'hFF);
        // R6 write during programming
        wr(17'h00313, 8'h99, 17'h00313, 8'h99);
        repeat (PROG_CYC + 10) @(negedge clk);

        // walk table readback (R9, R10, R3)
        for (int i = 0; i < 7; i++) begin
            rd(VEC[i][32:16], d, en, ea);
            check("R9 R10 R3 readback", d, VEC[i][7:0], 8'hFF);
        end
        rd(17'h00313, d, en, ea);
        check("R6 write during prog ignored", d, 8'h00, 8'hFF);
        rd(17'h00301, d, en, ea);
        check("R10 unloaded neighbour kept", d, 8'h00, 8'hFF);
        rd(17'h00310, d, en, ea);
        rd(17'h00310, d2, en, ea);
        check("R8 bit6 steady when done", {7'd0, d[6] ^ d2[6]}, 8'h00, 8'hFF);

        // R4 window retrigger, R2 address early / data late
        wr(17'h00020, 8'h44, 17'h00020, 8'h44);
        repeat (LOAD_WIN / 2) @(negedge clk);
        wr(17'h00021, 8'h11, 17'h00025, 8'h55);
        repeat (LOAD_WIN / 2) @(negedge clk);
        rd(17'h00020, d, en, ea);
        check("R4 page still open", d, 8'h00, 8'hFF);
        repeat (LOAD_WIN) @(negedge clk);
        rd(17'h00020, d, en, ea);
        check("R7 R8 status of late data", d, 8'h95, 8'hBF);
        repeat (PROG_CYC + 10) @(negedge clk);
        rd(17'h00020, d, en, ea);
        check("R9 first byte stored", d, 8'h44, 8'hFF);
        rd(17'h00021, d, en, ea);
        check("R2 late data at early address", d, 8'h55, 8'hFF);
        rd(17'h00025, d, en, ea);
        check("R2 late address unused", d, 8'h00, 8'hFF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule